// File: doc/BRIEF.md
# Bit-Reversed Post-Increment Address Generator

This block forms load and store addresses for buffers whose entries are visited in the bit-reversed order used by radix-2 FFT stages. For each request it takes a pointer and a modifier. The address it drives keeps the pointer's upper bits as they are and mirrors the low 16 bits, so bit 0 trades places with bit 15, bit 1 with bit 14, and so on. The pointer itself then moves on by the modifier using ordinary binary addition. The stored pointer therefore counts linearly, and only the presented address appears shuffled.

The block is used next to a register file. The caller sends the current pointer and modifier with a request strobe. One cycle later the block returns three things together: the address to use for the access, the advanced pointer to write back, and a write-back strobe. To walk a 2^k-entry buffer of byte elements in bit-reversed order, set the modifier to 1 << (16 - k). The base must be aligned to 64 KiB. Memory access and data formatting stay outside the block.

Top module: `brev_agen`

## Requirements
- R1: While rst_ni is low, and after it is released with no request yet made, addr_o, ptr_next_o and wb_o are all zero.
- R2: One cycle after a request, addr_o[31:16] equals the request's ptr_i[31:16], and addr_o[i] equals ptr_i[15-i] for i in 0..15.
- R3: One cycle after a request, ptr_next_o equals ptr_i + mod_i taken modulo 2^32, with no saturation.
- R4: wb_o is high in exactly the cycle after each cycle in which req_valid_i is high. It is low after every cycle in which req_valid_i is low.
- R5: addr_o, ptr_next_o and wb_o for one request change in the same cycle. Back-to-back requests give back-to-back results in the order they were issued.
- R6: In a cycle with req_valid_i low, ptr_i and mod_i are ignored, and addr_o and ptr_next_o keep their previous values.
- R7: addr_o is built from the pointer before its increment, never from ptr_next_o.
- R8: Starting from a 64 KiB-aligned base 0x00010000 with a modifier of 0x1000, and feeding each ptr_next_o back as the next ptr_i, four accesses give addresses 0x00010000, 0x00010008, 0x00010004 and 0x0001000C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request for this cycle |
| ptr_i | input | 32 | Pointer value before the access |
| mod_i | input | 32 | Post-increment amount |
| addr_o | output | 32 | Effective address with the low 16 bits mirrored |
| ptr_next_o | output | 32 | Pointer after the increment |
| wb_o | output | 1 | Strobe that marks ptr_next_o and addr_o as valid |

## Verification
The assertions check on every cycle that the strobe follows each request one cycle later. They also check that the upper address bits and the mirrored low bits come from the previous cycle's pointer, that the advanced pointer is the wrapped sum of the previous inputs, and that both outputs hold when no request is made. Only the bench's scenarios can show the points that span several requests. These are the ordering of back-to-back results, the wrap past 2^32 at specific values, and the fed-back sequence that must visit offsets 0, 8, 4 and 12. They also include the proof that the address comes from the pre-increment pointer when the modifier changes the low bits.

// File: rtl/agen_pkg.sv
package agen_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned REV_W  = 16;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] ptr;
    logic              wb;
  } agen_res_t;
endpackage

// File: rtl/agen_brev.sv
// Mirrors the low REV_W bits, passes the rest through.
module agen_brev #(
  parameter int unsigned W     = 32,
  parameter int unsigned REV_W = 16
) (
  input  logic [W-1:0] ptr_i,
  output logic [W-1:0] addr_o
);
  for (genvar i = 0; i < REV_W; i++) begin : g_rev
    assign addr_o[i] = ptr_i[REV_W-1-i];
  end
  if (W > REV_W) begin : g_hi
    assign addr_o[W-1:REV_W] = ptr_i[W-1:REV_W];
  end
endmodule

// File: rtl/agen_add.sv
// Linear post-increment, wraps modulo 2^W.
module agen_add #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  assign sum_o = a_i + b_i;
endmodule

// File: rtl/agen_out_reg.sv
module agen_out_reg
  import agen_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  agen_res_t d_i,
  output agen_res_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= '0;
    end else begin
      q_o.wb <= en_i;
      if (en_i) begin
        q_o.addr <= d_i.addr;
        q_o.ptr  <= d_i.ptr;
      end
    end
  end
endmodule

// File: rtl/brev_agen.sv
module brev_agen
  import agen_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic [ADDR_W-1:0] mod_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] ptr_next_o,
  output logic              wb_o
);
  agen_res_t res_d, res_q;

  // address comes from the pre-increment pointer
  agen_brev #(.W(ADDR_W), .REV_W(REV_W)) u_brev (
    .ptr_i  (ptr_i),
    .addr_o (res_d.addr)
  );

  agen_add #(.W(ADDR_W)) u_add (
    .a_i   (ptr_i),
    .b_i   (mod_i),
    .sum_o (res_d.ptr)
  );

  assign res_d.wb = req_valid_i;

  agen_out_reg u_oreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (req_valid_i),
    .d_i    (res_d),
    .q_o    (res_q)
  );

  assign addr_o     = res_q.addr;
  assign ptr_next_o = res_q.ptr;
  assign wb_o       = res_q.wb;
endmodule

// File: rtl/brev_agen_chk.sv
module brev_agen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [31:0] ptr_i,
  input logic [31:0] mod_i,
  input logic [31:0] addr_o,
  input logic [31:0] ptr_next_o,
  input logic        wb_o
);
  // R4
  wb_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> wb_o);
  // R4
  no_wb_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !wb_o);
  // R2
  upper_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> addr_o[31:16] == $past(ptr_i[31:16]));
  // R2
  mirror_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (addr_o[0] == $past(ptr_i[15])) && (addr_o[15] == $past(ptr_i[0])));
  // R3
  ptr_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> ptr_next_o == 32'($past(ptr_i) + $past(mod_i)));
  // R6
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> $stable(addr_o) && $stable(ptr_next_o));
endmodule

bind brev_agen brev_agen_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .ptr_i       (ptr_i),
  .mod_i       (mod_i),
  .addr_o      (addr_o),
  .ptr_next_o  (ptr_next_o),
  .wb_o        (wb_o)
);

// File: tb/sim_brev_agen.sv
`timescale 1ns/1ps
module sim_brev_agen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] ptr = '0;
  logic [31:0] mod = '0;
  logic [31:0] addr, ptr_next;
  logic        wb;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] exp_addr_q[$];
  logic [31:0] exp_ptr_q[$];
  string       tag_q[$];
  logic [31:0] last_addr = '0;
  logic [31:0] last_ptr = '0;

  always #2 clk = ~clk;

  brev_agen u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_valid_i (req_valid),
    .ptr_i       (ptr),
    .mod_i       (mod),
    .addr_o      (addr),
    .ptr_next_o  (ptr_next),
    .wb_o        (wb)
  );

  function automatic logic [31:0] mirror16(input logic [31:0] p);
    logic [31:0] r;
    r = p;
    for (int i = 0; i < 16; i++) r[i] = p[15-i];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: one request per call, on the falling edge
  task automatic issue(input logic [31:0] p, input logic [31:0] m,
                       input logic [31:0] ea, input string req);
    @(negedge clk);
    req_valid = 1'b1;
    ptr = p;
    mod = m;
    exp_addr_q.push_back(ea);
    exp_ptr_q.push_back(p + m);
    tag_q.push_back(req);
  endtask

  task automatic idle(input int n, input logic [31:0] junk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      ptr = junk ^ 32'(k);
      mod = ~junk;
    end
  endtask

  // monitor: sample on the falling edge, results appear one cycle after issue
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (wb) begin
        if (exp_addr_q.size() == 0) begin
          check("R4 unexpected wb", 32'(wb), 32'd0);
        end else begin
          string t;
          t = tag_q.pop_front();
          check({t, " addr"}, addr, exp_addr_q.pop_front());
          check({t, " ptr_next R5"}, ptr_next, exp_ptr_q.pop_front());
        end
        last_addr = addr;
        last_ptr = ptr_next;
      end else begin
        // R6 hold when idle
        check("R6 addr hold", addr, last_addr);
        check("R6 ptr hold", ptr_next, last_ptr);
      end
    end
  end

  initial begin
    #40000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] p;
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 addr reset", addr, 32'd0);
    check("R1 ptr reset", ptr_next, 32'd0);
    check("R1 wb reset", 32'(wb), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 addr after release", addr, 32'd0);
    check("R1 wb after release", 32'(wb), 32'd0);

    // R2 mirroring patterns
    issue(32'hABCD_0001, 32'd0, 32'hABCD_8000, "R2 bit0");
    issue(32'h1234_8000, 32'd4, 32'h1234_0001, "R2 bit15");
    issue(32'h0000_00F0, 32'd1, mirror16(32'h0000_00F0), "R2 nibble");
    issue(32'hFFFF_A5C3, 32'd2, mirror16(32'hFFFF_A5C3), "R2 mixed");
    idle(3, 32'hDEAD_BEEF);

    // R3 wrap modulo 2^32
    issue(32'hFFFF_F000, 32'h0000_2000, mirror16(32'hFFFF_F000), "R3 wrap");
    issue(32'hFFFF_FFFF, 32'h0000_0001, mirror16(32'hFFFF_FFFF), "R3 wrap to zero");
    idle(2, 32'h5555_AAAA);

    // R7 address from pre-increment pointer when modifier alters low bits
    issue(32'h0000_0001, 32'h0000_0001, 32'h0000_8000, "R7 pre-increment");
    idle(1, 32'h0F0F_0F0F);

    // R8 fed-back bit-reversed walk
    p = 32'h0001_0000;
    issue(p, 32'h1000, 32'h0001_0000, "R8 step0"); p = p + 32'h1000;
    issue(p, 32'h1000, 32'h0001_0008, "R8 step1"); p = p + 32'h1000;
    issue(p, 32'h1000, 32'h0001_0004, "R8 step2"); p = p + 32'h1000;
    issue(p, 32'h1000, 32'h0001_000C, "R8 step3");
    idle(4, 32'h1357_9BDF);

    // R4: every request drained
    check("R4 queue drained", 32'(exp_addr_q.size()), 32'd0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule